// File: doc/BRIEF.md
# Protected-Write Watchdog Timer

This block is a watchdog for a small microcontroller. Software drives it through a single byte-wide control register on a plain write/read bus. Every configuration change takes two bus writes. The first write sets an arm bit. The bus write that comes straight after it must target the same register, and that second write is the one that takes effect. If any other bus access comes between the two, the arm state is lost.

The counter advances on a prescaled tick input. If software does not kick it within the selected period, the watchdog expires and takes one of two actions. It can emit a one-clock system reset pulse, or it can raise an interrupt request that stays latched until acknowledged. The interrupt request has no mask, so the watchdog also works as a long-interval timer. A nonvolatile lock input, active low, pins the block to enabled, reset-on-expiry mode. The timeout field can still be changed while locked.

Control byte layout: bits [7:4] timeout select, bit 3 interrupt select, bit 2 kick, bit 1 enable, bit 0 arm.

Top module: `wdg_guard`

## Requirements
- R1: After reset the control byte reads 0xF2 (timeout select 15, interrupt select 0, enable 1, arm 0), and both the reset pulse and the interrupt request are low.
- R2: A control write with bit 0 set arms the register. The next bus transaction, if it is a control write, loads the timeout select, interrupt select and enable fields, and the arm state clears. A read taken while armed shows bit 0 as 1.
- R3: A control write made while not armed leaves the timeout select, interrupt select and enable fields unchanged.
- R4: A read, or a write to any other address, made while armed cancels the arm state, so the following control write has no effect. Idle cycles do not cancel it.
- R5: Timeout select values n = 0 to 9 give an expiry after 2^(n+4) ticks counted from the last kick. Values 10 to 15 give the same period as 9 (8192 ticks).
- R6: With interrupt select 0, expiry drives the reset output high for exactly one clock cycle, and the counter restarts.
- R7: With interrupt select 1, expiry sets the interrupt request and produces no reset pulse. The request stays high until the acknowledge input is asserted. The counter restarts at each expiry, so expiries repeat once per period.
- R8: An armed control write with bit 2 set restarts the count from zero. Bit 2 always reads back as 0.
- R9: While the lock input is low, enable reads 1 and interrupt select reads 0 whatever software writes, and expiry produces a reset pulse. The timeout select field still accepts armed writes.
- R10: With enable 0, ticks produce neither a reset pulse nor an interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Bus register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the read strobe |
| tick_in | input | 1 | Prescaled timebase tick, one count per clock it is high |
| lock_n | input | 1 | Nonvolatile lock, low forces enabled reset mode |
| irq_ack | input | 1 | Acknowledge for the interrupt request |
| sys_rst_pulse | output | 1 | One-clock system reset request |
| irq_req | output | 1 | Latched, unmaskable watchdog interrupt request |

## Verification
The bench measures the exact number of ticks to expiry for a short, a middle and a reserved timeout code. A design that shifts the period by one tick, or does not clamp the reserved codes, gives the wrong count. It breaks the arm sequence with an interposed read, with an interposed write to another address, and with an unarmed write. A design that lets any of these through shows a changed readback. In interrupt mode it holds off the acknowledge and then times the second expiry, which catches a request that self-clears, a stray reset pulse, or a counter that does not restart. It also kicks partway through a period, disables the block, and writes forbidden values under lock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef struct packed {
    logic [3:0] tsel;
    logic       isel;
    logic       kick;
    logic       en;
    logic       arm;
  } wdg_ctrl_t;

  localparam int unsigned WDG_TSEL_W = 4;

  // Mask of period-1 for a timeout code, saturated at max_code.
  function automatic logic [31:0] wdg_limit(input logic [3:0] code,
                                            input int unsigned max_code,
                                            input int unsigned cnt_w);
    int unsigned c;
    logic [31:0] full;
    c = (code > max_code) ? max_code : code;
    full = (32'd1 << cnt_w) - 32'd1;
    return full >> (max_code - c);
  endfunction

endpackage

// File: rtl/wdg_regif.sv
module wdg_regif
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter logic [3:0]  TSEL_RST  = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              lock_n,
  output logic [7:0]        rdata_o,
  output logic              en_o,
  output logic              isel_o,
  output logic [3:0]        tsel_o,
  output logic              kick_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  wdg_ctrl_t wd;
  logic      hit, commit, armed_q, en_q, isel_q;
  logic [3:0] tsel_q;
  logic [7:0] rdata_q;

  assign wd     = wdg_ctrl_t'(bus_wdata);
  assign hit    = bus_wr && (bus_addr == CTRL_A);
  assign commit = hit && armed_q;
  assign kick_o = commit && wd.kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      en_q    <= 1'b1;
      isel_q  <= 1'b0;
      tsel_q  <= TSEL_RST;
      rdata_q <= 8'h00;
    end else begin
      if (commit) begin
        armed_q <= 1'b0;
        tsel_q  <= wd.tsel;
        en_q    <= wd.en;
        isel_q  <= wd.isel;
      end else if (hit) begin
        armed_q <= wd.arm;
      end else if (bus_wr || bus_rd) begin
        armed_q <= 1'b0;
      end
      if (!lock_n) begin
        en_q   <= 1'b1;
        isel_q <= 1'b0;
      end
      if (bus_rd) begin
        rdata_q <= (bus_addr == CTRL_A) ?
                   {tsel_q, isel_q, 1'b0, en_q, armed_q} : 8'h00;
      end
    end
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign isel_o  = isel_q;
  assign tsel_o  = tsel_q;

  AST_NO_CFG_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (hit && !armed_q) |=> ($stable(tsel_q) && $stable(isel_q))); // R3
  AST_ARM_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || (bus_wr && !hit)) |=> !armed_q); // R4
  AST_LOCK_PINS: assert property (@(posedge clk) disable iff (rst)
    $past(!lock_n) |-> (en_q && !isel_q)); // R9

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4,
  parameter int unsigned MAX_CODE  = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [3:0] tsel_i,
  input  logic       tick_i,
  input  logic       kick_i,
  output logic       expire_o
);

  localparam int unsigned CNT_W = BASE_LOG2 + MAX_CODE;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             at_end;

  assign lim      = CNT_W'(wdg_limit(tsel_i, MAX_CODE, CNT_W));
  assign at_end   = (cnt_q >= lim);
  assign expire_o = en_i && tick_i && !kick_i && at_end;

  always_ff @(posedge clk) begin
    if (rst || kick_i || !en_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(kick_i) |-> (cnt_q == '0)); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/wdg_event.sv
module wdg_event (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic isel_i,
  input  logic ack_i,
  output logic rst_pulse_o,
  output logic irq_o
);

  logic pulse_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pulse_q <= expire_i && !isel_i;
      if (expire_i && isel_i) irq_q <= 1'b1;
      else if (ack_i)         irq_q <= 1'b0;
    end
  end

  assign rst_pulse_o = pulse_q;
  assign irq_o       = irq_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_i) |=> irq_q); // R7
  AST_NO_RST_IN_IRQ: assert property (@(posedge clk) disable iff (rst)
    (expire_i && isel_i) |=> !pulse_q); // R7

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned BASE_LOG2 = 4,
  parameter int unsigned MAX_CODE  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_in,
  input  logic              lock_n,
  input  logic              irq_ack,
  output logic              sys_rst_pulse,
  output logic              irq_req
);

  localparam logic [3:0] TSEL_RST = 4'hF;

  logic       en, isel, kick, expire;
  logic [3:0] tsel;

  wdg_regif #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TSEL_RST(TSEL_RST)
  ) regif_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .lock_n(lock_n),
    .rdata_o(bus_rdata), .en_o(en), .isel_o(isel), .tsel_o(tsel),
    .kick_o(kick)
  );

  wdg_counter #(
    .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)
  ) cnt_i (
    .clk(clk), .rst(rst), .en_i(en), .tsel_i(tsel), .tick_i(tick_in),
    .kick_i(kick), .expire_o(expire)
  );

  wdg_event evt_i (
    .clk(clk), .rst(rst), .expire_i(expire), .isel_i(isel),
    .ack_i(irq_ack), .rst_pulse_o(sys_rst_pulse), .irq_o(irq_req)
  );

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sys_rst_pulse && $stable(irq_req) || irq_ack); // R10

endmodule

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb_top;

  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] CTRL = '0;
  localparam logic [ADDR_W-1:0] OTHER = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic tick_in = 1'b0, lock_n = 1'b1, irq_ack = 1'b0;
  logic sys_rst_pulse, irq_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdg_guard dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_in(tick_in), .lock_n(lock_n), .irq_ack(irq_ack),
    .sys_rst_pulse(sys_rst_pulse), .irq_req(irq_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = CTRL;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] cbyte(input int ts, input bit is, input bit kk, input bit en);
    return {4'(ts), is, kk, en, 1'b0};
  endfunction

  task automatic cfg(input logic [7:0] v);
    wr(CTRL, 8'h01);
    wr(CTRL, v);
  endtask

  // Ticks every cycle until reset pulse; returns edge count, 0 on timeout.
  task automatic run_to_pulse(output int n);
    n = 0;
    tick_in = 1'b1;
    for (int i = 1; i <= 9000; i++) begin
      @(negedge clk);
      if (sys_rst_pulse) begin n = i; break; end
    end
    tick_in = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check(!sys_rst_pulse && !irq_req, "R1 outputs", int'(sys_rst_pulse), 0);
    rd(d);
    check(d == 8'hF2, "R1 readback", d, 8'hF2);
  endtask

  task automatic t_period(input int code, input int exp_n);
    int n;
    cfg(cbyte(code, 1'b0, 1'b1, 1'b1));
    run_to_pulse(n);
    check(n == exp_n, code > 9 ? "R5 reserved code period" : "R5 period", n, exp_n);
    @(negedge clk);
    check(!sys_rst_pulse, "R6 one-cycle pulse", int'(sys_rst_pulse), 0);
    check(!irq_req, "R6 no irq", int'(irq_req), 0);
  endtask

  task automatic t_cfg_write;
    logic [7:0] d;
    wr(CTRL, 8'h01);
    rd(d); // cancels the arm
    check(d[0] == 1'b1, "R2 armed readback", d[0], 1);
    cfg(cbyte(6, 1'b0, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    rd(d);
    check(d == 8'h62, "R2 armed write loads", d, 8'h62);
  endtask

  task automatic t_unarmed;
    logic [7:0] d;
    wr(CTRL, cbyte(3, 1'b1, 1'b0, 1'b0));
    rd(d);
    check(d == 8'h62, "R3 unarmed write ignored", d, 8'h62);
  endtask

  task automatic t_cancel;
    logic [7:0] d;
    wr(CTRL, 8'h01);
    rd(d);
    wr(CTRL, cbyte(4, 1'b1, 1'b0, 1'b0));
    rd(d);
    check(d == 8'h62, "R4 read cancels arm", d, 8'h62);
    wr(CTRL, 8'h01);
    wr(OTHER, 8'h55);
    wr(CTRL, cbyte(4, 1'b1, 1'b0, 1'b0));
    rd(d);
    check(d == 8'h62, "R4 other write cancels arm", d, 8'h62);
    wr(CTRL, 8'h01);
    repeat (4) @(negedge clk);
    wr(CTRL, cbyte(5, 1'b0, 1'b0, 1'b1));
    rd(d);
    check(d == 8'h52, "R4 idle keeps arm", d, 8'h52);
  endtask

  task automatic t_irq;
    int first = 0, second = 0;
    bit pulse_seen = 0, held = 1;
    cfg(cbyte(1, 1'b1, 1'b1, 1'b1)); // 32 ticks
    tick_in = 1'b1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      irq_ack = 1'b0;
      if (sys_rst_pulse) pulse_seen = 1;
      if (first != 0 && i > first && i <= first + 5 && !irq_req) held = 0;
      if (first != 0 && i == first + 5) irq_ack = 1'b1;
      if (first != 0 && i == first + 6)
        check(!irq_req, "R7 ack clears irq", int'(irq_req), 0);
      if (irq_req && first == 0) first = i;
      else if (irq_req && first != 0 && i > first + 6 && second == 0) second = i;
    end
    tick_in = 1'b0;
    check(first == 32, "R7 first expiry", first, 32);
    check(held, "R7 irq held until ack", int'(held), 1);
    check(second == 64, "R7 counter restarts", second, 64);
    check(!pulse_seen, "R7 no reset pulse", int'(pulse_seen), 0);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_kick;
    int n;
    logic [7:0] d;
    cfg(cbyte(2, 1'b0, 1'b1, 1'b1)); // 64 ticks
    tick_in = 1'b1;
    repeat (40) @(negedge clk);
    tick_in = 1'b0;
    cfg(cbyte(2, 1'b0, 1'b1, 1'b1));
    check(!sys_rst_pulse, "R8 no early expiry", int'(sys_rst_pulse), 0);
    rd(d);
    check(d[2] == 1'b0, "R8 kick bit reads 0", d[2], 0);
    run_to_pulse(n);
    check(n == 64, "R8 kick restarts count", n, 64);
    @(negedge clk);
  endtask

  task automatic t_disable;
    bit seen = 0;
    cfg(cbyte(0, 1'b0, 1'b1, 1'b0));
    tick_in = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sys_rst_pulse || irq_req) seen = 1;
    end
    tick_in = 1'b0;
    check(!seen, "R10 disabled is quiet", int'(seen), 0);
  endtask

  task automatic t_lock;
    logic [7:0] d;
    int n;
    lock_n = 1'b0;
    @(negedge clk);
    cfg(cbyte(2, 1'b1, 1'b1, 1'b0));
    rd(d);
    check(d == 8'h22, "R9 lock pins en/isel, tsel writable", d, 8'h22);
    run_to_pulse(n);
    check(n == 64, "R9 locked expiry resets", n, 64);
    check(!irq_req, "R9 no irq under lock", int'(irq_req), 0);
    @(negedge clk);
    lock_n = 1'b1;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg_write();
    t_unarmed();
    t_cancel();
    t_period(0, 16);
    t_period(3, 128);
    t_period(12, 8192);
    t_irq();
    t_kick();
    t_disable();
    t_lock();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule